// File: doc/BRIEF.md
# Status flags and condition evaluator

This block holds the four arithmetic status flags of a 32-bit datapath: negative (N), zero (Z), carry (C) and overflow (V). Every executed operation presents its result word together with the adder carry-out, the adder signed-overflow indication and the shifter carry-out. A two-bit class input says whether the operation was an add, a subtract, a shift or a logical operation. When the set-flags enable is high, the flags are loaded on the next rising clock edge. The rules for which flags change depend on the class.

Alongside the flag register sits a combinational evaluator. It takes a 4-bit condition field from the instruction being issued and says, from the flags now held, whether a conditional instruction may proceed. The arithmetic itself, instruction decode and writeback are outside the block.

The subtract datapath is taken to compute `a + ~b + 1`. Its carry-out is therefore already the not-borrow value. The parameter `SUB_CARRY_IS_BORROW` selects the other convention, in which the adder reports a borrow that the block inverts.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears N, Z, C and V to 0.
- R2: While `set_flags` is low, all four flags keep their values across clock edges, whatever the other inputs do.
- R3: On an update, N takes bit 31 (the top bit) of `result`, and Z is 1 exactly when all 32 bits of `result` are 0.
- R4: On an update with class 2'b00 (add, including compare-negative), C takes `add_carry` and V takes `add_ovf`.
- R5: On an update with class 2'b01 (subtract, including compare), C takes the not-borrow value and V takes `add_ovf`. With the default parameter, `add_carry` is the carry-out of `a + ~b + 1`, so it is loaded unchanged: comparing 5 with 6 gives C = 0.
- R6: On an update with class 2'b10 (shift), C takes `shift_carry` and V keeps its value.
- R7: On an update with class 2'b11 (logical), C and V both keep their values. N and Z still update.
- R8: Conditions 0000 to 0111 test one flag: 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0.
- R9: Condition 1000 (unsigned higher) passes when C=1 and Z=0. Condition 1001 (unsigned lower or same) passes when C=0 or Z=1.
- R10: Condition 1010 (signed greater or equal) passes when N equals V. Condition 1011 (signed less) passes when N differs from V.
- R11: Condition 1100 (signed greater) passes when Z=0 and N equals V. Condition 1101 (signed less or equal) passes when Z=1 or N differs from V.
- R12: Condition 1110 always passes and condition 1111 never passes.
- R13: `cond_pass` is combinational from the registered flags only. A flag write presented in the same cycle is not seen until after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| result | input | 32 | Result word of the executed operation |
| add_carry | input | 1 | Adder carry-out |
| add_ovf | input | 1 | Adder signed-overflow indication |
| shift_carry | input | 1 | Last bit shifted out by the shifter |
| op_class | input | 2 | Operation class: 00 add, 01 subtract, 10 shift, 11 logical |
| set_flags | input | 1 | Enables the flag update at the next edge |
| cond | input | 4 | Condition field to evaluate |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| cond_pass | output | 1 | High when the condition holds for the current flags |

## Verification
The assertions take for granted that every input is a known value outside reset and that `op_class` is stable for the whole cycle in which `set_flags` is high. They do not assume any agreement between `result`, `add_carry` and `add_ovf`, because the block loads them as given. The bench drives every input on the falling edge from time zero, so nothing is ever X or changes near the active edge. It derives result, carry and overflow together from a 33-bit model of the operation, so the stimulus stays self-consistent. The N-and-Z-both-set combination cannot be produced through the ports, so the condition table is covered over the twelve reachable flag combinations.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    typedef enum logic [1:0] {
        OPC_ADD   = 2'b00,
        OPC_SUB   = 2'b01,
        OPC_SHIFT = 2'b10,
        OPC_LOGIC = 2'b11
    } op_class_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    localparam int COND_W = 4;

endpackage

// File: rtl/sfu_flag_next.sv
module sfu_flag_next
    import sfu_pkg::*;
#(
    parameter int DATA_W              = 32,
    parameter bit SUB_CARRY_IS_BORROW = 1'b0
) (
    input  flags_t              flags_q,
    input  logic [DATA_W-1:0]   result,
    input  logic                add_carry,
    input  logic                add_ovf,
    input  logic                shift_carry,
    input  op_class_e           op_class,
    output flags_t              flags_nxt
);
    localparam int MSB = DATA_W - 1;

    logic sub_c;

    // Convention of the subtract carry picked by parameter
    generate
        if (SUB_CARRY_IS_BORROW) begin : g_borrow_in
            assign sub_c = ~add_carry;
        end else begin : g_notborrow_in
            assign sub_c = add_carry;
        end
    endgenerate

    always_comb begin
        flags_nxt   = flags_q;
        flags_nxt.n = result[MSB];
        flags_nxt.z = (result == '0);
        unique case (op_class)
            OPC_ADD: begin
                flags_nxt.c = add_carry;
                flags_nxt.v = add_ovf;
            end
            OPC_SUB: begin
                flags_nxt.c = sub_c;
                flags_nxt.v = add_ovf;
            end
            OPC_SHIFT: begin
                flags_nxt.c = shift_carry;
            end
            default: begin
                // logical: carry and overflow retained
            end
        endcase
    end

endmodule

// File: rtl/sfu_cond_eval.sv
module sfu_cond_eval
    import sfu_pkg::*;
(
    input  flags_t              flags,
    input  logic [COND_W-1:0]   cond,
    output logic                pass
);
    logic base;

    // Even codes give the base test; odd codes are its complement.
    always_comb begin
        unique case (cond[COND_W-1:1])
            3'd0:    base = flags.z;
            3'd1:    base = flags.c;
            3'd2:    base = flags.n;
            3'd3:    base = flags.v;
            3'd4:    base = flags.c & ~flags.z;
            3'd5:    base = ~(flags.n ^ flags.v);
            3'd6:    base = ~flags.z & ~(flags.n ^ flags.v);
            default: base = 1'b1;
        endcase
        pass = base ^ cond[0];
    end

endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
    import sfu_pkg::*;
#(
    parameter int DATA_W              = 32,
    parameter bit SUB_CARRY_IS_BORROW = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DATA_W-1:0]   result,
    input  logic                add_carry,
    input  logic                add_ovf,
    input  logic                shift_carry,
    input  logic [1:0]          op_class,
    input  logic                set_flags,
    input  logic [COND_W-1:0]   cond,
    output logic                flag_n,
    output logic                flag_z,
    output logic                flag_c,
    output logic                flag_v,
    output logic                cond_pass
);
    localparam int MSB = DATA_W - 1;

    typedef struct packed {
        flags_t flags;
    } state_t;

    state_t state_d, state_q;
    flags_t flags_nxt;

    sfu_flag_next #(
        .DATA_W              (DATA_W),
        .SUB_CARRY_IS_BORROW (SUB_CARRY_IS_BORROW)
    ) u_next (
        .flags_q     (state_q.flags),
        .result      (result),
        .add_carry   (add_carry),
        .add_ovf     (add_ovf),
        .shift_carry (shift_carry),
        .op_class    (op_class_e'(op_class)),
        .flags_nxt   (flags_nxt)
    );

    always_comb begin
        state_d = state_q;
        if (set_flags) begin
            state_d.flags = flags_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    sfu_cond_eval u_cond (
        .flags (state_q.flags),
        .cond  (cond),
        .pass  (cond_pass)
    );

    assign flag_n = state_q.flags.n;
    assign flag_z = state_q.flags.z;
    assign flag_c = state_q.flags.c;
    assign flag_v = state_q.flags.v;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)); // R1
    AST_HOLD_NO_SET: assert property (@(posedge clk) disable iff (rst)
        !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R2
    AST_N_FROM_MSB: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_n == $past(result[MSB]))); // R3
    AST_Z_ALL_ZERO: assert property (@(posedge clk) disable iff (rst)
        set_flags |=> (flag_z == ($past(result) == '0))); // R3
    AST_ADD_CV: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_class == 2'b00) |=>
            (flag_c == $past(add_carry) && flag_v == $past(add_ovf))); // R4
    AST_SUB_V: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_class == 2'b01) |=> (flag_v == $past(add_ovf))); // R5
    AST_SHIFT_V_KEEP: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_class == 2'b10) |=>
            ($stable(flag_v) && flag_c == $past(shift_carry))); // R6
    AST_LOGIC_CV_KEEP: assert property (@(posedge clk) disable iff (rst)
        (set_flags && op_class == 2'b11) |=> $stable({flag_c, flag_v})); // R7
    AST_GE_NV: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'b1010) |-> (cond_pass == (flag_n == flag_v))); // R10
    AST_ALWAYS_PASS: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'b1110) |-> cond_pass); // R12
    AST_NEVER_PASS: assert property (@(posedge clk) disable iff (rst)
        (cond == 4'b1111) |-> !cond_pass); // R12

endmodule

// File: tb/tb_status_flag_unit.sv
module tb_status_flag_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic [31:0] result;
    logic        add_carry, add_ovf, shift_carry;
    logic [1:0]  op_class;
    logic        set_flags;
    logic [3:0]  cond;
    logic        flag_n, flag_z, flag_c, flag_v, cond_pass;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    status_flag_unit dut (
        .clk(clk), .rst(rst), .result(result), .add_carry(add_carry),
        .add_ovf(add_ovf), .shift_carry(shift_carry), .op_class(op_class),
        .set_flags(set_flags), .cond(cond), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .cond_pass(cond_pass)
    );

    function automatic logic [3:0] flags_now();
        return {flag_n, flag_z, flag_c, flag_v};
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Independent condition model, written per code
    function automatic logic cond_model(logic [3:0] f, logic [3:0] cc);
        logic n, z, c, v;
        {n, z, c, v} = f;
        case (cc)
            4'b0000: return z;
            4'b0001: return !z;
            4'b0010: return c;
            4'b0011: return !c;
            4'b0100: return n;
            4'b0101: return !n;
            4'b0110: return v;
            4'b0111: return !v;
            4'b1000: return c && !z;
            4'b1001: return !c || z;
            4'b1010: return (n && v) || (!n && !v);
            4'b1011: return (n && !v) || (!n && v);
            4'b1100: return !z && ((n && v) || (!n && !v));
            4'b1101: return z || (n && !v) || (!n && v);
            4'b1110: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // Drive at a falling edge, let one rising edge pass, end at next falling edge
    task automatic step(logic [31:0] res, logic ac, logic ao, logic sc,
                        logic [1:0] cls, logic sf);
        result = res; add_carry = ac; add_ovf = ao; shift_carry = sc;
        op_class = cls; set_flags = sf;
        @(negedge clk);
        set_flags = 1'b0;
    endtask

    task automatic do_arith(logic [31:0] a, logic [31:0] b, bit is_sub, string req);
        logic [32:0] s;
        logic        ov;
        logic [3:0]  exp;
        if (is_sub) begin
            s  = {1'b0, a} + {1'b0, ~b} + 33'd1;
            ov = (a[31] != b[31]) && (s[31] != a[31]);
        end else begin
            s  = {1'b0, a} + {1'b0, b};
            ov = (a[31] == b[31]) && (s[31] != a[31]);
        end
        exp = {s[31], s[31:0] == 32'd0, s[32], ov};
        step(s[31:0], s[32], ov, ~s[32], is_sub ? 2'b01 : 2'b00, 1'b1);
        chk(req, $sformatf("flags %h op %h", a, b), {28'd0, flags_now()}, {28'd0, exp});
    endtask

    // Load a chosen flag set through the add class (N and Z not both 1)
    task automatic load_flags(logic [3:0] f);
        logic [31:0] r;
        r = f[3] ? 32'h8000_0000 : (f[2] ? 32'd0 : 32'd1);
        step(r, f[1], f[0], 1'b0, 2'b00, 1'b1);
    endtask

    task automatic test_reset();
        load_flags(4'b1011);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "flags after reset", {28'd0, flags_now()}, 32'd0);
    endtask

    task automatic test_hold();
        load_flags(4'b0110);
        step(32'h8000_0000, 1'b0, 1'b1, 1'b1, 2'b00, 1'b0);
        chk("R2", "hold with set low", {28'd0, flags_now()}, 32'h6);
        step(32'd0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0);
        chk("R2", "hold second pattern", {28'd0, flags_now()}, 32'h6);
    endtask

    task automatic test_add();
        do_arith(32'h7FFF_FFFF, 32'd1, 0, "R4");
        do_arith(32'h8000_0000, 32'h8000_0000, 0, "R4");
        do_arith(32'hFFFF_FFFF, 32'd1, 0, "R3");
        do_arith(32'h7FFF_FFFF, 32'h8000_0000, 0, "R3");
        for (int i = 0; i < 24; i++) do_arith($urandom, $urandom, 0, "R4");
    endtask

    task automatic test_sub();
        do_arith(32'h8000_0000, 32'd1, 1, "R5");
        do_arith(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, "R5");
        do_arith(32'd0, 32'd0, 1, "R5");
        do_arith(32'h8000_0000, 32'h7FFF_FFFF, 1, "R5");
        for (int i = 0; i < 24; i++) do_arith($urandom, $urandom, 1, "R5");
    endtask

    task automatic test_cmp_5_6();
        do_arith(32'd5, 32'd6, 1, "R5");
        chk("R5", "C after 5 cmp 6", {31'd0, flag_c}, 32'd0);
        cond = 4'b1001; #1;
        chk("R9", "lower-or-same after 5 cmp 6", {31'd0, cond_pass}, 32'd1);
        cond = 4'b1000; #1;
        chk("R9", "higher after 5 cmp 6", {31'd0, cond_pass}, 32'd0);
        cond = 4'b1011; #1;
        chk("R10", "signed less after 5 cmp 6", {31'd0, cond_pass}, 32'd1);
    endtask

    task automatic test_shift();
        load_flags(4'b0001);
        step(32'h8000_0000, 1'b0, 1'b0, 1'b1, 2'b10, 1'b1);
        chk("R6", "shift carry 1, V kept", {28'd0, flags_now()}, 32'hB);
        load_flags(4'b0010);
        step(32'd0, 1'b1, 1'b1, 1'b0, 2'b10, 1'b1);
        chk("R6", "shift carry 0, V kept", {28'd0, flags_now()}, 32'h4);
    endtask

    task automatic test_logic();
        load_flags(4'b0011);
        step(32'd0, 1'b0, 1'b0, 1'b0, 2'b11, 1'b1);
        chk("R7", "logical keeps C V", {28'd0, flags_now()}, 32'h7);
        load_flags(4'b0100);
        step(32'h8000_0001, 1'b1, 1'b1, 1'b1, 2'b11, 1'b1);
        chk("R7", "logical keeps C V low", {28'd0, flags_now()}, 32'h8);
    endtask

    task automatic test_cond_table();
        for (int f = 0; f < 16; f++) begin
            if (f[3] && f[2]) continue;
            load_flags(f[3:0]);
            for (int c = 0; c < 16; c++) begin
                string req;
                cond = c[3:0];
                #1;
                req = (c < 8) ? "R8" : (c < 10) ? "R9" : (c < 12) ? "R10" :
                      (c < 14) ? "R11" : "R12";
                chk(req, $sformatf("cond %b flags %b", c[3:0], f[3:0]),
                    {31'd0, cond_pass}, {31'd0, cond_model(f[3:0], c[3:0])});
            end
        end
    endtask

    task automatic test_pass_registered();
        load_flags(4'b0000);
        cond = 4'b0000;
        result = 32'd0; add_carry = 1'b0; add_ovf = 1'b0; shift_carry = 1'b0;
        op_class = 2'b00; set_flags = 1'b1;
        #1;
        chk("R13", "pass before edge uses old Z", {31'd0, cond_pass}, 32'd0);
        @(negedge clk);
        set_flags = 1'b0;
        chk("R13", "pass after edge uses new Z", {31'd0, cond_pass}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; result = '0; add_carry = 0; add_ovf = 0; shift_carry = 0;
        op_class = 2'b00; set_flags = 0; cond = 4'b1110;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "flags out of reset", {28'd0, flags_now()}, 32'd0);
        test_hold();
        test_add();
        test_sub();
        test_cmp_5_6();
        test_shift();
        test_logic();
        test_cond_table();
        test_pass_registered();
        test_reset();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule